// File: doc/BRIEF.md
# Source Descriptor Ring Copy Engine

This block drains a circular queue of transfer descriptors and turns each one into a burst of 32-bit words on an output stream. Software fills descriptor slots through a write port into a small local descriptor memory. It then publishes the work by moving the producer index. The engine walks from its consumer index up to, but not including, the producer index. For each descriptor it fetches words from a buffer-read port and presents them on a valid/ready stream.

Descriptors can be chained with a gather flag so that several buffers leave as one stream transfer with a single completion. A per-descriptor swap flag reverses the byte order of every word. The metadata of the first descriptor in a chain travels on a sideband for the whole transfer. A programmable length cap truncates oversized descriptors and records the event in a sticky error bit. Watermark and ring-full flags let software pace its producer.

Top module: `ce_src_engine`

## Requirements
- R1: After reset the producer and consumer indices are 0, the size register (log2 of entries) equals LOG2_DEPTH, the length cap is 0xFFFF, the watermark register holds low 0 in bits [15:0] and high equal to the entry count in bits [31:16], and out_valid is low.
- R2: The engine reads descriptors only while consumer and producer indices differ, and stays idle with out_valid low when they are equal. The descriptor for ring index i sits in memory slot (base + i) modulo the memory depth.
- R3: A descriptor of n bytes leaves as max(1, ceil(n/4)) beats. Beat k reads buffer byte address addr+4k, and out_keep has its low min(4, n-4k) bits set. A zero-length descriptor gives a single beat with out_keep 0.
- R4: When flags bit 14 is set, each output word carries its buffer word with the four bytes in reversed order; otherwise the word is passed unchanged.
- R5: A descriptor with flags bit 15 set is joined to the next one. out_last rises only on the final beat of the first descriptor without bit 15. out_meta shows flags bits [13:0] of the chain's first descriptor throughout the chain.
- R6: The consumer index (register 3) steps by one, modulo the ring size, after each descriptor's final beat is accepted. copy_done pulses for one cycle, one cycle after the accepted out_last beat.
- R7: A descriptor longer than the cap (register 4) is sent as exactly cap bytes and sets status bit 0 (register 6). The bit stays set until software writes 1 to it. A length equal to the cap is not flagged.
- R8: ring_full is high exactly when (producer − (consumer − 1)) masked by the ring mask is 0.
- R9: With pending = (producer − consumer) masked, wm_high is high when pending ≥ the high field and wm_low is high when pending ≤ the low field.
- R10: While out_valid is high and out_ready low, the beat's address, keep, last and meta hold steady and the consumer index does not move.
- R11: The size register takes log2 of the entry count, and values above LOG2_DEPTH are clamped to LOG2_DEPTH. Writes to the producer index (register 2) are masked by (entries − 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base, 1 size log2, 2 producer, 3 consumer, 4 length cap, 5 watermarks, 6 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| dsc_we | input | 1 | Descriptor memory write strobe |
| dsc_slot | input | LOG2_DEPTH | Descriptor memory slot |
| dsc_addr | input | 32 | Descriptor buffer byte address |
| dsc_len | input | 16 | Descriptor byte count |
| dsc_flags | input | 16 | Flags: 15 gather, 14 swap, 13:0 metadata |
| buf_addr | output | 32 | Buffer read byte address |
| buf_data | input | 32 | Buffer word at buf_addr, same cycle |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 32 | Stream word |
| out_keep | output | 4 | Valid byte lanes, lane 0 first |
| out_last | output | 1 | Final beat of a transfer |
| out_meta | output | 14 | Metadata of the chain's first descriptor |
| copy_done | output | 1 | One-cycle completion pulse per transfer |
| ring_full | output | 1 | Ring has one free slot left |
| wm_low | output | 1 | Pending count at or below low mark |
| wm_high | output | 1 | Pending count at or above high mark |

## Verification
The embedded assertions watch on every cycle that a stalled beat holds still, that the consumer index only moves after an accepted beat, that each accepted last beat is followed by exactly one copy_done pulse, and that keep lanes stay contiguous. Byte counts, address stepping, swapping, gather chaining, metadata choice, truncation and the error bit can only be shown by the bench's scenarios, which compare every beat against values worked out from the descriptor. The same holds for ring wrap at two sizes and for the full and watermark flags under backpressure.

// File: rtl/ce_pkg.sv
package ce_pkg;
    localparam int META_W   = 14;
    localparam int BIT_GATH = 15;
    localparam int BIT_SWAP = 14;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [15:0] flags;
    } desc_t;

    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_SIZE   = 3'd1,
        SEL_PROD   = 3'd2,
        SEL_CONS   = 3'd3,
        SEL_CAP    = 3'd4,
        SEL_WMARK  = 3'd5,
        SEL_STATUS = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/ce_desc_mem.sv
module ce_desc_mem
    import ce_pkg::*;
#(
    parameter int LOG2_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [LOG2_DEPTH-1:0] wr_slot,
    input  desc_t                 wr_desc,
    input  logic [LOG2_DEPTH-1:0] rd_slot,
    output desc_t                 rd_desc
);
    localparam int DEPTH = 1 << LOG2_DEPTH;

    desc_t slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slots_q[wr_slot] <= wr_desc;
    end

    assign rd_desc = slots_q[rd_slot];
endmodule

// File: rtl/ce_beat_fmt.sv
module ce_beat_fmt (
    input  logic [31:0] word_in,
    input  logic [15:0] remain,
    input  logic        swap,
    output logic [31:0] word_out,
    output logic [3:0]  keep,
    output logic        tail
);
    always_comb begin
        word_out = swap ? {word_in[7:0], word_in[15:8], word_in[23:16], word_in[31:24]}
                        : word_in;
        tail     = (remain <= 16'd4);
        if (remain >= 16'd4) keep = 4'hF;
        else                 keep = (4'b0001 << remain[1:0]) - 4'b0001;
    end
endmodule

// File: rtl/ce_src_engine.sv
module ce_src_engine
    import ce_pkg::*;
#(
    parameter int LOG2_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [2:0]            reg_sel,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  dsc_we,
    input  logic [LOG2_DEPTH-1:0] dsc_slot,
    input  logic [31:0]           dsc_addr,
    input  logic [15:0]           dsc_len,
    input  logic [15:0]           dsc_flags,
    output logic [31:0]           buf_addr,
    input  logic [31:0]           buf_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [31:0]           out_data,
    output logic [3:0]            out_keep,
    output logic                  out_last,
    output logic [META_W-1:0]     out_meta,
    output logic                  copy_done,
    output logic                  ring_full,
    output logic                  wm_low,
    output logic                  wm_high
);
    localparam int DEPTH = 1 << LOG2_DEPTH;
    localparam int IW    = LOG2_DEPTH;
    localparam int SW    = $clog2(LOG2_DEPTH + 1);

    typedef struct packed {
        logic [IW-1:0]     base;
        logic [SW-1:0]     lg;
        logic [IW-1:0]     prod;
        logic [IW-1:0]     cons;
        logic [15:0]       cap;
        logic [15:0]       wlo;
        logic [15:0]       whi;
        logic              err;
        logic              run;
        logic              chain;
        logic              gath;
        logic              swap;
        logic [31:0]       addr;
        logic [15:0]       remain;
        logic [META_W-1:0] meta;
        logic              done;
    } st_t;

    st_t   st_d, st_q;
    desc_t cur_desc;
    logic  [IW:0]   size_w;
    logic  [IW-1:0] mask;
    logic  [IW-1:0] pend;
    logic  [31:0]   fmt_word;
    logic  [3:0]    fmt_keep;
    logic           fmt_tail;

    ce_desc_mem #(.LOG2_DEPTH(LOG2_DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (dsc_we),
        .wr_slot (dsc_slot),
        .wr_desc ({dsc_addr, dsc_len, dsc_flags}),
        .rd_slot (st_q.base + st_q.cons),
        .rd_desc (cur_desc)
    );

    ce_beat_fmt u_fmt (
        .word_in  (buf_data),
        .remain   (st_q.remain),
        .swap     (st_q.swap),
        .word_out (fmt_word),
        .keep     (fmt_keep),
        .tail     (fmt_tail)
    );

    always_comb begin
        size_w = (IW + 1)'(1) << st_q.lg;
        mask   = IW'(size_w - 1'b1);
        pend   = (st_q.prod - st_q.cons) & mask;
    end

    // next-state logic
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_BASE:   st_d.base = reg_wdata[IW-1:0];
                SEL_SIZE:   st_d.lg   = (reg_wdata > 32'(LOG2_DEPTH)) ? SW'(LOG2_DEPTH)
                                                                    : reg_wdata[SW-1:0];
                SEL_PROD:   st_d.prod = reg_wdata[IW-1:0] & mask;
                SEL_CAP:    st_d.cap  = reg_wdata[15:0];
                SEL_WMARK:  begin
                    st_d.wlo = reg_wdata[15:0];
                    st_d.whi = reg_wdata[31:16];
                end
                SEL_STATUS: if (reg_wdata[0]) st_d.err = 1'b0;
                default: ;
            endcase
        end

        if (!st_q.run) begin
            if (st_q.cons != st_q.prod) begin
                st_d.run    = 1'b1;
                st_d.addr   = cur_desc.addr;
                st_d.gath   = cur_desc.flags[BIT_GATH];
                st_d.swap   = cur_desc.flags[BIT_SWAP];
                if (cur_desc.len > st_q.cap) begin
                    st_d.remain = st_q.cap;
                    st_d.err    = 1'b1;
                end else begin
                    st_d.remain = cur_desc.len;
                end
                if (!st_q.chain) st_d.meta = cur_desc.flags[META_W-1:0];
            end
        end else if (out_ready) begin
            if (!fmt_tail) begin
                st_d.remain = st_q.remain - 16'd4;
                st_d.addr   = st_q.addr + 32'd4;
            end else begin
                st_d.run  = 1'b0;
                st_d.cons = (st_q.cons + 1'b1) & mask;
                if (st_q.gath) begin
                    st_d.chain = 1'b1;
                end else begin
                    st_d.chain = 1'b0;
                    st_d.done  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lg  <= SW'(LOG2_DEPTH);
            st_q.cap <= 16'hFFFF;
            st_q.whi <= 16'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_BASE:   reg_rdata = 32'(st_q.base);
            SEL_SIZE:   reg_rdata = 32'(st_q.lg);
            SEL_PROD:   reg_rdata = 32'(st_q.prod);
            SEL_CONS:   reg_rdata = 32'(st_q.cons);
            SEL_CAP:    reg_rdata = 32'(st_q.cap);
            SEL_WMARK:  reg_rdata = {st_q.whi, st_q.wlo};
            SEL_STATUS: reg_rdata = {31'd0, st_q.err};
            default:    reg_rdata = 32'd0;
        endcase
    end

    assign buf_addr  = st_q.addr;
    assign out_valid = st_q.run;
    assign out_data  = fmt_word;
    assign out_keep  = fmt_keep;
    assign out_last  = fmt_tail & ~st_q.gath;
    assign out_meta  = st_q.meta;
    assign copy_done = st_q.done;
    assign ring_full = (((st_q.prod - (st_q.cons - 1'b1)) & mask) == '0);
    assign wm_low    = (16'(pend) <= st_q.wlo);
    assign wm_high   = (16'(pend) >= st_q.whi);

    // a stalled beat must not change
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(buf_addr) && $stable(out_keep)
                                    && $stable(out_last) && $stable(out_meta));

    // consumer index only moves after an accepted beat
    assert_cons_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cons) |-> $past(out_valid && out_ready));

    // accepted last beat gives a completion pulse on the next cycle
    assert_last_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> copy_done);

    // completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !copy_done);

    // keep lanes are contiguous from lane 0
    assert_keep_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_keep & (out_keep + 4'd1)) == 4'd0));
endmodule

// File: tb/sim_ce_src_engine.sv
module sim_ce_src_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dsc_we = 1'b0;
    logic [LG-1:0] dsc_slot = '0;
    logic [31:0] dsc_addr = '0;
    logic [15:0] dsc_len = '0;
    logic [15:0] dsc_flags = '0;
    logic [31:0] buf_addr;
    logic [31:0] buf_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_keep;
    logic        out_last;
    logic [13:0] out_meta;
    logic        copy_done, ring_full, wm_low, wm_high;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] bufword(input logic [31:0] a);
        return a * 32'h9E3779B1 + 32'h13579BDF;
    endfunction

    assign buf_data = bufword(buf_addr);

    ce_src_engine #(.LOG2_DEPTH(LG)) u0 (.*);

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] s, input logic [31:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [31:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic creg(input logic [2:0] s, input logic [31:0] exp, input string req, input string what);
        logic [31:0] v;
        rreg(s, v);
        chk(v == exp, req, what, v, exp);
    endtask

    task automatic wdesc(input int slot, input logic [31:0] a, input logic [15:0] n, input logic [15:0] f);
        dsc_we = 1'b1; dsc_slot = LG'(slot); dsc_addr = a; dsc_len = n; dsc_flags = f;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    // check every beat of one descriptor (n = bytes actually sent)
    task automatic expect_desc(input logic [31:0] a, input int n, input bit swp, input bit ends,
                               input logic [13:0] meta, input string req);
        int beats = (n == 0) ? 1 : (n + 3) / 4;
        for (int b = 0; b < beats; b++) begin
            int t = 0;
            int rem;
            logic [31:0] w;
            logic [3:0] k;
            logic lst;
            while (!out_valid && t < 50) begin
                @(negedge clk); t++;
            end
            rem = n - 4 * b;
            w = bufword(a + 32'(4 * b));
            if (swp) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
            k = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            lst = ends && (b == beats - 1);
            chk(out_valid, req, "beat valid", 32'(out_valid), 32'd1);
            chk(out_data == w, req, "beat data", out_data, w);
            chk(out_keep == k && out_last == lst && out_meta == meta, req, "keep/last/meta",
                {out_keep, 13'd0, out_last, out_meta}, {k, 13'd0, lst, meta});
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v, hold_d;
        logic [3:0] hold_k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        creg(3'd2, 0, "R1", "producer");
        creg(3'd3, 0, "R1", "consumer");
        creg(3'd1, LG, "R1", "size");
        creg(3'd4, 32'hFFFF, "R1", "cap");
        creg(3'd5, {16'd8, 16'd0}, "R1", "watermarks");
        chk(!out_valid && !ring_full, "R1", "idle outputs", {30'd0, out_valid, ring_full}, 0);
        repeat (3) @(negedge clk);
        chk(!out_valid, "R2", "idle with equal indices", 32'(out_valid), 0);

        // sweep lengths 0..9, swap alternating, wraps the 8-entry ring (R2 R3 R4 R6)
        for (int i = 0; i < 10; i++) begin
            logic [31:0] a = 32'h1000 + 32'(i * 64);
            logic [13:0] m = 14'(i * 37 + 5);
            wdesc(i % 8, a, 16'(i), {1'b0, 1'(i % 2), m});
            wreg(3'd2, 32'((i + 1) % 8));
            expect_desc(a, i, (i % 2) == 1, 1'b1, m, "R3");
            chk(copy_done, "R6", "done pulse", 32'(copy_done), 1);
            creg(3'd3, 32'((i + 1) % 8), "R6", "consumer step/wrap");
            @(negedge clk);
            chk(!copy_done, "R6", "done one cycle", 32'(copy_done), 0);
        end
        repeat (2) @(negedge clk);
        chk(!out_valid, "R2", "drained ring idle", 32'(out_valid), 0);

        // gather chain at ring idx 2,3,4 (R5 R4)
        wdesc(2, 32'h2000, 16'd5, {2'b10, 14'h111});
        wdesc(3, 32'h2100, 16'd4, {2'b11, 14'h222});
        wdesc(4, 32'h2200, 16'd3, {2'b00, 14'h333});
        wreg(3'd2, 5);
        expect_desc(32'h2000, 5, 1'b0, 1'b0, 14'h111, "R5");
        chk(!copy_done, "R5", "no done mid chain", 32'(copy_done), 0);
        expect_desc(32'h2100, 4, 1'b1, 1'b0, 14'h111, "R5");
        chk(!copy_done, "R5", "no done mid chain", 32'(copy_done), 0);
        expect_desc(32'h2200, 3, 1'b0, 1'b1, 14'h111, "R5");
        chk(copy_done, "R5", "one done at chain end", 32'(copy_done), 1);
        creg(3'd3, 5, "R6", "consumer after chain");

        // length cap (R7)
        wreg(3'd4, 6);
        wdesc(5, 32'h3000, 16'd20, 14'h0AA);
        wreg(3'd2, 6);
        expect_desc(32'h3000, 6, 1'b0, 1'b1, 14'h0AA, "R7");
        creg(3'd6, 1, "R7", "error set");
        wreg(3'd6, 1);
        creg(3'd6, 0, "R7", "error cleared");
        wdesc(6, 32'h3100, 16'd6, 14'h0BB);
        wreg(3'd2, 7);
        expect_desc(32'h3100, 6, 1'b0, 1'b1, 14'h0BB, "R7");
        creg(3'd6, 0, "R7", "equal length not flagged");
        wreg(3'd4, 32'hFFFF);
        wdesc(7, 32'h3200, 16'd4, 14'h0CC);
        wreg(3'd2, 0);
        expect_desc(32'h3200, 4, 1'b0, 1'b1, 14'h0CC, "R2");
        creg(3'd3, 0, "R2", "consumer back to 0");

        // smaller ring at offset 4, backpressure, full and watermarks (R8 R9 R10 R11)
        wreg(3'd1, 2);
        wreg(3'd0, 4);
        wreg(3'd5, {16'd3, 16'd1});
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) wdesc(4 + i, 32'h4000 + 32'(i * 256), 16'd8, 14'(i + 1));
        wreg(3'd2, 3);
        repeat (3) @(negedge clk);
        chk(ring_full, "R8", "full at one free slot", 32'(ring_full), 1);
        chk(wm_high && !wm_low, "R9", "high mark reached", {30'd0, wm_high, wm_low}, 32'd2);
        chk(out_valid && out_data == bufword(32'h4000), "R2", "slot is base+index", out_data, bufword(32'h4000));
        hold_d = out_data; hold_k = out_keep;
        repeat (4) @(negedge clk);
        chk(out_data == hold_d && out_keep == hold_k && out_valid, "R10", "stalled beat held", out_data, hold_d);
        creg(3'd3, 0, "R10", "consumer frozen");
        out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            expect_desc(32'h4000 + 32'(i * 256), 8, 1'b0, 1'b1, 14'(i + 1), "R10");
            if (i == 0) chk(!ring_full, "R8", "not full after one", 32'(ring_full), 0);
        end
        creg(3'd3, 3, "R6", "consumer in small ring");
        chk(wm_low && !wm_high, "R9", "low mark when empty", {30'd0, wm_high, wm_low}, 32'd1);
        wdesc(7, 32'h5000, 16'd1, 14'h3FFF);
        wreg(3'd2, 4);
        creg(3'd2, 0, "R11", "producer masked");
        expect_desc(32'h5000, 1, 1'b0, 1'b1, 14'h3FFF, "R11");
        creg(3'd3, 0, "R11", "consumer wraps at 4");
        wreg(3'd1, 7);
        creg(3'd1, LG, "R11", "size clamped");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule